// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from two external pins and from a parameterized group of internal peripheral sources. It then presents one request at a time to a processor model, together with the vector to fetch. Each source has a pending flag and an enable bit. A single global enable gates every request. Among the sources that are both enabled and pending, the one with the lowest vector number wins.

The two external pins are always sensed, whatever their direction on the chip. Each pin has its own sense mode: low level, falling edge or rising edge. The pins pass through a two-flop synchronizer. A third register holds the previous sampled value for edge detection. Edge events set a latched flag. A low-level request has no flag and lasts only while the pin is held low.

The processor takes a request with a one-cycle acknowledge strobe. On that same clock edge the serviced flag and the global enable are both cleared. A return strobe sets the global enable again. Software may also set the global enable directly, which allows nesting. Software clears a flag by writing 1 to it. Software programs the block through a small register port. Address map: 0 control (bit 0 global enable), 1 external enables, 2 external flags, 3 sense modes, 4 peripheral enables, 5 peripheral flags.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, the global enable is 0, and `irq_req` is low.
- R2: In the external-enable register at address 1, bit 7 enables pin 1 and bit 6 enables pin 0. Every other bit reads as 0, whatever value is written.
- R3: At address 3, bits [1:0] set the mode of pin 0 and bits [3:2] set the mode of pin 1. The codes are: 00 low level, 01 no request, 10 falling edge, 11 rising edge. A selected edge shows in the external flag register (pin 1 at bit 7, pin 0 at bit 6) after the third rising clock edge that follows the pin change.
- R4: In low-level mode a pin never sets its flag. It requests only while the pin is low, and the request ends two clock edges after the pin goes high.
- R5: A flag is set even while its enable bit or the global enable is 0. It stays set until it is serviced or cleared by software.
- R6: The vectors are: pin 0 is 1, pin 1 is 2, and peripheral source i is 3+i. When several sources are enabled and pending, the lowest vector is presented first.
- R7: `irq_req` is high exactly when the global enable is 1 and at least one source is both enabled and pending. `irq_vec` then carries the winning vector.
- R8: An `irq_ack` while `irq_req` is high clears the global enable and the flag of the presented source on that clock edge.
- R9: A `ret_strobe` sets the global enable.
- R10: Writing 1 to a bit of a flag register (address 2 or 5) clears that flag. Writing 0 leaves the flag unchanged.
- R11: Software writes bit 0 of address 0 to set or clear the global enable, including inside a handler (nesting).
- R12: If an event for a source arrives on the same edge that its flag is cleared, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| ext_pin | input | 2 | Raw external interrupt pins |
| periph_req | input | NUM_PERIPH | Peripheral event strobes |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | VEC_W | Vector of the presented request |
| irq_ack | input | 1 | One-cycle acknowledge from the processor |
| ret_strobe | input | 1 | Return-from-interrupt strobe |

## Verification
A lost or stuck pending flag shows up on `irq_vec` as a missing or repeated vector within one cycle of the next acknowledge. A flag that was wrongly cleared never reaches `irq_req` at all. A global enable in the wrong state shows as `irq_req` that stays asserted after an acknowledge, or that stays low after a return strobe, on the very next cycle. A wrong edge detector or sense decoder shows in the external flag register at the third clock edge after the pin moves. The edge tests sample both before and at that edge.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_PERIPH = 6,
  parameter int VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic [1:0]            ext_pin,
  input  logic [NUM_PERIPH-1:0] periph_req,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vec,
  input  logic                  irq_ack,
  input  logic                  ret_strobe
);
  localparam int NSRC = NUM_PERIPH + 2;
  localparam int SW = $clog2(NSRC);

  logic                  gie_q;
  logic [1:0]            ext_en, ext_flag;
  logic [3:0]            sense;
  logic [NUM_PERIPH-1:0] p_en, p_flag;
  logic [1:0]            s1, s2, s3;
  logic [1:0]            edge_hit, lvl_hit;
  logic [NSRC-1:0]       active, take_mask;
  logic [SW-1:0]         sel;
  logic                  take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {ext_pin, s1, s2};

  for (genvar k = 0; k < 2; k++) begin : g_pin
    wire [1:0] mode = sense[2*k +: 2];
    assign edge_hit[k] = (mode == 2'b10 && !s2[k] && s3[k]) ||
                         (mode == 2'b11 && s2[k] && !s3[k]);
    assign lvl_hit[k]  = (mode == 2'b00) && !s2[k];
  end

  assign active = {p_flag & p_en, (ext_flag | lvl_hit) & ext_en};

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (active[i]) sel = SW'(i);
  end

  assign irq_req   = gie_q && (|active);
  assign irq_vec   = VEC_W'(sel) + VEC_W'(1);
  assign take      = irq_ack && irq_req;
  assign take_mask = take ? (NSRC'(1) << sel) : '0;

  wire wr_ctl  = reg_we && reg_addr == 3'd0;
  wire wr_emsk = reg_we && reg_addr == 3'd1;
  wire wr_eflg = reg_we && reg_addr == 3'd2;
  wire wr_sns  = reg_we && reg_addr == 3'd3;
  wire wr_pmsk = reg_we && reg_addr == 3'd4;
  wire wr_pflg = reg_we && reg_addr == 3'd5;

  wire [1:0]            e_w1c = wr_eflg ? reg_wdata[7:6] : 2'b00;
  wire [NUM_PERIPH-1:0] p_w1c = wr_pflg ? reg_wdata[NUM_PERIPH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      ext_en   <= '0;
      ext_flag <= '0;
      sense    <= '0;
      p_en     <= '0;
      p_flag   <= '0;
    end else begin
      if (take)            gie_q <= 1'b0;
      else if (ret_strobe) gie_q <= 1'b1;
      else if (wr_ctl)     gie_q <= reg_wdata[0];
      if (wr_emsk) ext_en <= reg_wdata[7:6];
      if (wr_sns)  sense  <= reg_wdata[3:0];
      if (wr_pmsk) p_en   <= reg_wdata[NUM_PERIPH-1:0];
      ext_flag <= (ext_flag & ~e_w1c & ~take_mask[1:0]) | edge_hit;
      p_flag   <= (p_flag & ~p_w1c & ~take_mask[NSRC-1:2]) | periph_req;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {7'b0, gie_q};
      3'd1:    reg_rdata = {ext_en, 6'b0};
      3'd2:    reg_rdata = {ext_flag, 6'b0};
      3'd3:    reg_rdata = {4'b0, sense};
      3'd4:    reg_rdata = 8'(p_en);
      3'd5:    reg_rdata = 8'(p_flag);
      default: reg_rdata = 8'b0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_PERIPH = 6,
  parameter int VEC_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq_req,
  input logic                  irq_ack,
  input logic                  ret_strobe,
  input logic [VEC_W-1:0]      irq_vec,
  input logic                  gie_q,
  input logic [NUM_PERIPH-1:0] p_flag,
  input logic [NUM_PERIPH-1:0] periph_req
);
  logic [NUM_PERIPH-1:0] svc_bit;
  always_comb begin
    svc_bit = '0;
    for (int i = 0; i < NUM_PERIPH; i++)
      if (int'(irq_vec) == i + 3) svc_bit[i] = 1'b1;
  end

  a_r7_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie_q);

  a_r6_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) >= 1 && int'(irq_vec) <= NUM_PERIPH + 2));

  a_r8_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !gie_q);

  a_r9_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !(irq_ack && irq_req)) |=> gie_q);

  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && svc_bit != '0 && (svc_bit & periph_req) == '0)
      |=> ((p_flag & $past(svc_bit)) == '0));

  a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_req != '0) |=> ((p_flag & $past(periph_req)) == $past(periph_req)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .ret_strobe(ret_strobe), .irq_vec(irq_vec), .gie_q(gie_q),
  .p_flag(p_flag), .periph_req(periph_req)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam int NP = 6;
  localparam int VW = 8;

  logic clk = 0, rst_n = 0, reg_we = 0, irq_ack = 0, ret_strobe = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] ext_pin = 0;
  logic [NP-1:0] periph_req = 0;
  logic irq_req;
  logic [VW-1:0] irq_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_ctrl #(.NUM_PERIPH(NP), .VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .periph_req(periph_req), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .ret_strobe(ret_strobe));

  always #2.5 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, int exp);
    reg_addr = a; #0.5;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse_ack();  irq_ack = 1;    step(); irq_ack = 0;    endtask
  task automatic pulse_ret();  ret_strobe = 1; step(); ret_strobe = 0; endtask

  function automatic int exp_vec(logic [NP-1:0] pf, logic [NP-1:0] pm);
    for (int i = 0; i < NP; i++) if (pf[i] && pm[i]) return i + 3;
    return 0;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [NP-1:0] pf, pm, preq, w1c;
    logic g, ack, take;
    int ev;
    void'($urandom(32'h1234));
    step(3);
    rst_n = 1;
    step();
    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 0);
    chk("R1 irq_req", int'(irq_req), 0);

    // R2 mask layout
    wr(1, 8'hFF);
    rd_chk("R2 ext mask readback", 1, 8'hC0);
    wr(1, 8'h00);

    // R3 rising edge on pin 0
    wr(3, 8'h03);
    ext_pin[0] = 1;
    step(2);
    rd_chk("R3 rise before 3rd edge", 2, 8'h00);
    step();
    rd_chk("R3 rise flag", 2, 8'h40);
    wr(2, 8'h40);
    rd_chk("R10 w1c ext0", 2, 8'h00);
    // R3 falling edge on pin 1
    wr(3, 8'h0B);
    ext_pin[1] = 1;
    step(4);
    rd_chk("R3 rising ignored in fall mode", 2, 8'h00);
    ext_pin[1] = 0;
    step(3);
    rd_chk("R3 fall flag", 2, 8'h80);
    // R10 writing 0 has no effect
    wr(2, 8'h00);
    rd_chk("R10 write 0 no effect", 2, 8'h80);
    wr(2, 8'h80);
    rd_chk("R10 w1c ext1", 2, 8'h00);
    // R3 code 01 gives no request
    wr(3, 8'h09);
    ext_pin[0] = 0; step(4);
    ext_pin[0] = 1; step(4);
    rd_chk("R3 mode 01 no flag", 2, 8'h00);

    // R4 low level on pin 1 (pin 1 already low)
    wr(3, 8'h01);
    wr(1, 8'h80);
    wr(0, 8'h01);
    chk("R4 level request", int'(irq_req), 1);
    chk("R6 ext1 vector", int'(irq_vec), 2);
    rd_chk("R4 no level flag", 2, 8'h00);
    ext_pin[1] = 1;
    step();
    chk("R4 request held one edge", int'(irq_req), 1);
    step();
    chk("R4 request gone", int'(irq_req), 0);
    wr(0, 8'h00); wr(1, 8'h00);

    // R8 edge flag on pin 0 serviced
    wr(3, 8'h03);
    ext_pin[0] = 0; step(4);
    ext_pin[0] = 1; step(3);
    wr(1, 8'h40);
    chk("R5 masked by gie", int'(irq_req), 0);
    wr(0, 8'h01);
    chk("R6 ext0 vector", int'(irq_vec), 1);
    pulse_ack();
    rd_chk("R8 ext flag cleared", 2, 8'h00);
    rd_chk("R8 gie cleared", 0, 0);
    wr(1, 8'h00);

    // R5 R6 R7 peripheral priority
    periph_req = 6'b010101; step(); periph_req = 0;
    rd_chk("R5 latched while masked", 5, 8'h15);
    wr(4, 8'h3F);
    chk("R7 no request without gie", int'(irq_req), 0);
    wr(0, 8'h01);
    chk("R7 request", int'(irq_req), 1);
    chk("R6 first vec", int'(irq_vec), 3);
    pulse_ack();
    chk("R8 gie off after ack", int'(irq_req), 0);
    rd_chk("R8 periph flag cleared", 5, 8'h14);
    pulse_ret();
    rd_chk("R9 gie after return", 0, 1);
    chk("R6 second vec", int'(irq_vec), 5);
    pulse_ack();
    wr(0, 8'h01);
    chk("R11 nesting by sw gie", int'(irq_req), 1);
    chk("R6 third vec", int'(irq_vec), 7);
    pulse_ack();
    pulse_ret();
    chk("R7 idle when none pending", int'(irq_req), 0);
    rd_chk("R8 all serviced", 5, 8'h00);

    // R12 event same edge as software clear
    wr(0, 8'h00);
    periph_req = 6'b000010; step(); periph_req = 0;
    periph_req = 6'b000010;
    wr(5, 8'h02);
    periph_req = 0;
    rd_chk("R12 event wins over w1c", 5, 8'h02);
    wr(5, 8'h3F);

    // random peripheral traffic against a model
    wr(0, 8'h01);
    pf = '0; pm = 6'h3F; g = 1;
    for (int c = 0; c < 3000; c++) begin
      ev = exp_vec(pf, pm);
      chk("R7 rand req", int'(irq_req), int'(g && ev != 0));
      if (g && ev != 0) chk("R6 rand vec", int'(irq_vec), ev);
      preq = '0;
      for (int i = 0; i < NP; i++) if ($urandom_range(7) == 0) preq[i] = 1;
      ack = irq_req && ($urandom_range(1) == 1);
      ret_strobe = ($urandom_range(3) == 0);
      w1c = '0;
      if ($urandom_range(9) == 0) begin
        w1c = NP'($urandom);
        reg_we = 1; reg_addr = 5; reg_wdata = 8'(w1c);
      end
      periph_req = preq; irq_ack = ack;
      take = ack && g && ev != 0;
      if (take) pf[ev-3] = 1'b0;
      pf = (pf & ~w1c) | preq;
      if (take) g = 0; else if (ret_strobe) g = 1;
      step();
      reg_we = 0; periph_req = 0; irq_ack = 0; ret_strobe = 0;
    end
    done = 1;
    summary();
  end
endmodule